// File: doc/BRIEF.md
# Sequenced Byte-Array Multiplier

This block multiplies two operands using a single combinational 8x8 unsigned multiplier array that is reused across several cycles. Four operations are offered: byte by byte unsigned, byte by byte two's-complement, halfword by halfword unsigned, and halfword by halfword two's-complement. Wide products are built by accumulating four byte partial products, one per cycle, into a 32-bit accumulator. Signed products are recovered from the unsigned product: the accumulator's upper part is corrected by one subtraction per negative operand.

A caller raises `start` for one cycle with the operation code and both operands. The block captures them, asserts `busy` while it works, then pulses `done` for one cycle with the final product on `result`. The product stays there until the next operation completes. The block drives no carry, zero or overflow indication.

Top module: `mulseq_top`

## Requirements
- R1: Operation code 2'b00 multiplies `a[7:0]` by `b[7:0]` as unsigned numbers. It gives the 16-bit product on `result[15:0]` with `result[31:16]` zero, and `done` is high in the first cycle after the cycle in which `start` was sampled.
- R2: Operation code 2'b01 multiplies `a[7:0]` by `b[7:0]` as two's-complement numbers. It gives the product sign-extended to 32 bits, and `done` is high in the third cycle after the start cycle.
- R3: Operation code 2'b10 multiplies `a` by `b` as 16-bit unsigned numbers into a 32-bit `result`, and `done` is high in the fourth cycle after the start cycle.
- R4: Operation code 2'b11 multiplies `a` by `b` as 16-bit two's-complement numbers into a 32-bit two's-complement `result`, and `done` is high in the sixth cycle after the start cycle.
- R5: `done` is high for exactly one cycle per accepted operation. `busy` is high from the cycle after acceptance up to the cycle before `done`, and `busy` and `done` are never high together.
- R6: A `start` sampled while `busy` is high is ignored. The running operation's result and timing are unchanged, and no additional `done` pulse appears.
- R7: The operation code and operands are captured when `start` is accepted. Changing `op`, `a` or `b` while `busy` is high does not change the result.
- R8: `result` changes only in the cycle where `done` is high and holds its value otherwise, including while idle and during the next operation.
- R9: With `rst` high at a clock edge, `busy`, `done` and `result` are all zero after that edge.
- R10: In the two byte operations, `a[15:8]` and `b[15:8]` have no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation while idle |
| op | input | 2 | Operation code: 00 u8, 01 s8, 10 u16, 11 s16 |
| a | input | 16 | First operand; low byte only in byte modes |
| b | input | 16 | Second operand; low byte only in byte modes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product, held between completions |

## Verification
All four operations are run over every pair from the corner sets 0x00/0x7F/0x80/0xFF and 0x0000/0x7FFF/0x8000/0xFFFF. Each pair separates the sign corrections: only one operand negative, both negative, or the most negative value against itself. Random operands follow, issued back to back, including starts placed exactly in the `done` cycle. In byte modes the random upper operand bytes show whether anything outside the low byte leaks in. Further sequences hold `start` high and change the operands during a long signed operation, which separates a design that re-samples its inputs from one that captured them.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  typedef enum logic [1:0] {
    OP_U8  = 2'b00,
    OP_S8  = 2'b01,
    OP_U16 = 2'b10,
    OP_S16 = 2'b11
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIXB = 2'd2,
    ST_FIXA = 2'd3
  } seq_st_e;
endpackage

// File: rtl/mulseq_byte_mul.sv
module mulseq_byte_mul #(
  parameter int BW = 8
) (
  input  logic [BW-1:0]   x,
  input  logic [BW-1:0]   y,
  output logic [2*BW-1:0] p
);
  localparam int PW = 2 * BW;

  always_comb begin
    p = PW'(x) * PW'(y);
  end
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
  import mulseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] op_in,
  output logic       accept,
  output logic       fin,
  output logic       busy,
  output logic       done,
  output seq_st_e    st,
  output logic [1:0] step,
  output mul_op_e    op_q
);
  localparam logic [1:0] LAST_STEP = 2'd3;

  seq_st_e st_nxt;
  logic    last_mul;
  logic    is_wide;
  logic    is_sgn;

  assign is_wide = op_q[1];
  assign is_sgn  = op_q[0];
  assign busy    = (st != ST_IDLE);

  always_comb begin
    accept   = start && (st == ST_IDLE);
    last_mul = is_wide ? (step == LAST_STEP) : (step == 2'd0);
    fin      = ((st == ST_MUL) && last_mul && !is_sgn) || (st == ST_FIXA);
    st_nxt   = st;
    case (st)
      ST_IDLE: if (accept) st_nxt = ST_MUL;
      ST_MUL:  if (last_mul) st_nxt = is_sgn ? ST_FIXB : ST_IDLE;
      ST_FIXB: st_nxt = ST_FIXA;
      ST_FIXA: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      step <= 2'd0;
      op_q <= OP_U8;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      done <= fin;
      if (accept) begin
        step <= 2'd0;
        op_q <= mul_op_e'(op_in);
      end else if ((st == ST_MUL) && !last_mul) begin
        step <= step + 2'd1;
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && step == 2'd0));
  // R6
  no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> busy);
  // R6
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_q));
  // R1
  narrow_one_pp_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MUL && !op_q[1]) |-> step == 2'd0);
endmodule

// File: rtl/mulseq_accum.sv
module mulseq_accum
  import mulseq_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            fin,
  input  seq_st_e         st,
  input  logic [1:0]      step,
  input  mul_op_e         op_q,
  input  logic [2*BW-1:0] a_in,
  input  logic [2*BW-1:0] b_in,
  output logic [4*BW-1:0] result
);
  localparam int OW  = 2 * BW;
  localparam int RW  = 4 * BW;
  localparam int SHW = $clog2(RW);

  logic [OW-1:0]  a_q, b_q;
  logic [RW-1:0]  acc, acc_nxt, pp_ext;
  logic [BW-1:0]  sel_a, sel_b;
  logic [OW-1:0]  pp;
  logic [SHW-1:0] sh;
  logic [OW-1:0]  hi_w;
  logic [BW-1:0]  hi_n;
  logic [OW-1:0]  lo_n;
  logic           wide;

  assign wide = op_q[1];

  always_comb begin
    sel_a = step[1] ? a_q[OW-1:BW] : a_q[BW-1:0];
    sel_b = step[0] ? b_q[OW-1:BW] : b_q[BW-1:0];
    case (step)
      2'd0:    sh = '0;
      2'd3:    sh = SHW'(2 * BW);
      default: sh = SHW'(BW);
    endcase
  end

  mulseq_byte_mul #(.BW(BW)) u_arr (
    .x (sel_a),
    .y (sel_b),
    .p (pp)
  );

  assign pp_ext = RW'(pp) << sh;

  always_comb begin
    acc_nxt = acc;
    hi_w    = '0;
    hi_n    = '0;
    lo_n    = '0;
    case (st)
      ST_MUL: acc_nxt = (step == 2'd0) ? pp_ext : acc + pp_ext;
      ST_FIXB: begin
        if (wide) begin
          hi_w    = acc[RW-1:OW] - (b_q[OW-1] ? a_q : '0);
          acc_nxt = {hi_w, acc[OW-1:0]};
        end else begin
          hi_n    = acc[OW-1:BW] - (b_q[BW-1] ? a_q[BW-1:0] : '0);
          acc_nxt = {acc[RW-1:OW], hi_n, acc[BW-1:0]};
        end
      end
      ST_FIXA: begin
        if (wide) begin
          hi_w    = acc[RW-1:OW] - (a_q[OW-1] ? b_q : '0);
          acc_nxt = {hi_w, acc[OW-1:0]};
        end else begin
          hi_n    = acc[OW-1:BW] - (a_q[BW-1] ? b_q[BW-1:0] : '0);
          lo_n    = {hi_n, acc[BW-1:0]};
          acc_nxt = {{OW{lo_n[OW-1]}}, lo_n};
        end
      end
      default: acc_nxt = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      acc    <= '0;
      result <= '0;
    end else begin
      if (accept) begin
        a_q <= a_in;
        b_q <= b_in;
      end
      if (st != ST_IDLE) acc <= acc_nxt;
      if (fin) result <= acc_nxt;
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(result));
  // R7
  operand_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> ($stable(a_q) && $stable(b_q)));
  // R1
  u8_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && op_q == OP_U8) |=> result[RW-1:OW] == '0);
  // R2
  s8_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && op_q == OP_S8) |=> result[RW-1:OW] == {OW{result[OW-1]}});
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
  import mulseq_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [2*BW-1:0] a,
  input  logic [2*BW-1:0] b,
  output logic            busy,
  output logic            done,
  output logic [4*BW-1:0] result
);
  logic       accept;
  logic       fin;
  seq_st_e    st;
  logic [1:0] step;
  mul_op_e    op_q;

  mulseq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_in  (op),
    .accept (accept),
    .fin    (fin),
    .busy   (busy),
    .done   (done),
    .st     (st),
    .step   (step),
    .op_q   (op_q)
  );

  mulseq_accum #(.BW(BW)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .fin    (fin),
    .st     (st),
    .step   (step),
    .op_q   (op_q),
    .a_in   (a),
    .b_in   (b),
    .result (result)
  );

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));
endmodule

// File: tb/mulseq_top_tb.sv
module mulseq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        busy, done;
  logic [31:0] result;

  int nchk = 0;
  int errs = 0;
  bit finished = 0;

  mulseq_top u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_prod(logic [1:0] o, logic [15:0] x, logic [15:0] y);
    longint p;
    case (o)
      2'b00:   p = longint'(x[7:0]) * longint'(y[7:0]);
      2'b01:   p = longint'($signed(x[7:0])) * longint'($signed(y[7:0]));
      2'b10:   p = longint'(x) * longint'(y);
      default: p = longint'($signed(x)) * longint'($signed(y));
    endcase
    return p[31:0];
  endfunction

  function automatic int lat_of(logic [1:0] o);
    case (o)
      2'b00:   return 1;
      2'b01:   return 3;
      2'b10:   return 4;
      default: return 6;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] o);
    case (o)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // behavioural reference model, advanced on each rising edge
  logic        m_busy = 0, m_done = 0, m_live = 0;
  logic [31:0] m_res = 0, m_pend = 0;
  int          m_cnt = 0;
  string       m_tag = "R9";
  string       phase = "";

  always @(posedge clk) begin
    m_live = 1;
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = 0; m_cnt = 0; m_tag = "R9";
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1; m_busy = 0; m_res = m_pend;
        end
      end else if (start) begin
        m_pend = ref_prod(op, a, b);
        m_cnt  = lat_of(op);
        m_busy = 1;
        m_tag  = tag_of(op);
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s %s act=%h exp=%h", tag, phase, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (m_live && !finished) begin
      chk("R5", "busy", 32'(busy), 32'(m_busy));
      chk("R5", "done", 32'(done), 32'(m_done));
      chk((m_busy || m_done) ? m_tag : "R8", "result", result, m_res);
    end
  end

  task automatic issue(logic [1:0] o, logic [15:0] x, logic [15:0] y);
    op = o; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    logic [7:0]  c8 [4]  = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    logic [15:0] c16 [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "busy", 32'(busy), 0);
    chk("R9", "done", 32'(done), 0);
    chk("R9", "result", result, 0);
    rst = 1'b0;
    @(negedge clk);

    phase = "corner";
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          if (o < 2) issue(2'(o), {8'h00, c8[i]}, {8'h00, c8[j]});
          else       issue(2'(o), c16[i], c16[j]);
        end

    // R10: random upper bytes in byte modes
    phase = "R10";
    for (int k = 0; k < 60; k++) issue(2'(k % 2), 16'($urandom), 16'($urandom));

    // R1 R2 R3 R4: random operands back to back
    phase = "random";
    for (int k = 0; k < 120; k++) issue(2'($urandom % 4), 16'($urandom), 16'($urandom));

    // R6 R7: start held and inputs changed during a long signed operation
    phase = "R6/R7";
    for (int k = 0; k < 8; k++) begin
      op = 2'b11; a = (k == 0) ? 16'h8000 : 16'($urandom); b = (k == 0) ? 16'h7FFF : 16'($urandom);
      start = 1'b1;
      @(negedge clk);
      for (int t = 0; t < 4; t++) begin
        op = 2'(t); a = 16'($urandom); b = 16'($urandom);
        @(negedge clk);
      end
      start = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
    end

    // R8: idle with changing inputs and no start
    phase = "R8";
    for (int k = 0; k < 10; k++) begin
      op = 2'(k); a = 16'($urandom); b = 16'($urandom);
      @(negedge clk);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      errs++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, errs);
      $finish;
    end
  end
endmodule